// File: doc/BRIEF.md
# Fixed-Weight Codeword Sequencer

This block produces, one word per advance, every M-bit word that carries exactly N ones, in descending binary order. It is a pattern source for pseudoexhaustive testing of a combinational circuit in which no output depends on more than N inputs. Each of the C(M,N) words appears once per period, and the period then repeats. N and M are elaboration parameters and are meant to stay small, because the logic grows quickly with them.

The interface has only plain control pins. A synchronous reset loads the largest word, which has its N ones in the top positions. When the advance input is high at a clock edge, the word steps to the next smaller value of the same weight. A flag marks the smallest word, which has the ones in the bottom positions. An advance taken while the flag is high returns the word to the largest one. There is no data handshake. The consumer samples the word whenever it needs it and holds the advance input low to stall the sequence.

Top module: `cwc_counter`

## Requirements
- R1: In the clock cycle after a cycle with `rst_i` high, `code_o` equals the largest N-weight word, whose bits [M-1:M-N] are one and whose other bits are zero.
- R2: `code_o` has exactly N bits set in every cycle.
- R3: An advance taken while `last_o` is low loads the next smaller M-bit value that has N ones.
- R4: `last_o` is high exactly when `code_o` has bits [N-1:0] set and all other bits clear.
- R5: An advance taken while `last_o` is high loads the largest word from R1.
- R6: While `adv_i` is low, `code_o` keeps its value.
- R7: Starting from the word loaded by R1, C(M,N) advances visit every N-weight word once and return to the starting word. For N=2 and M=4 the words, written as bits [3:0], are 1100, 1010, 1001, 0110, 0101, 0011, after which the sequence returns to 1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Advance to the next codeword at this edge |
| code_o | output | M | Current N-out-of-M codeword |
| last_o | output | 1 | High on the final (smallest) codeword |

## Verification
The in-RTL assertions check the following in every cycle:
- the weight of the word;
- the hold when `adv_i` is low;
- the strict decrease on an ordinary advance;
- the return to the first word after the last one;
- agreement between the flag and the step logic that finds no pivot;
- the period length, measured with an advance counter.

Only the bench scenarios show the exact order of the sequence. They compare each word against an independent model that searches downward for the next value of equal weight, under random advance patterns. A second instance with N=2 and M=4 is compared against the literal six-word listing.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  // Binomial coefficient, evaluated at elaboration for small arguments.
  function automatic int unsigned cw_choose(input int unsigned n, input int unsigned m);
    longint unsigned acc;
    acc = 1;
    for (int unsigned i = 0; i < n; i++) begin
      acc = acc * (m - i) / (i + 1);
    end
    return int'(acc);
  endfunction

  // Width able to hold values 0..m.
  function automatic int unsigned cw_idx_width(input int unsigned m);
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/cwc_pivot_find.sv
// Locates the lowest bit position p (p >= 1) where word[p]=1 and word[p-1]=0.
// That one is the bit that moves down by one place on the next step.
module cwc_pivot_find #(
  parameter int unsigned M  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [M-1:0]  word_i,
  output logic [IW-1:0] pos_o,
  output logic          found_o
);
  always_comb begin
    pos_o   = '0;
    found_o = 1'b0;
    // Scan downward so the lowest match is the one that remains.
    for (int i = int'(M) - 1; i >= 1; i--) begin
      if (word_i[i] && !word_i[i-1]) begin
        pos_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwc_tail_count.sv
// Counts the ones strictly below position pos-1; those get repacked.
module cwc_tail_count #(
  parameter int unsigned M  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [M-1:0]  word_i,
  input  logic [IW-1:0] pos_i,
  output logic [IW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < int'(M); j++) begin
      if ((j + 1) < int'(pos_i) && word_i[j]) cnt_o = cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/cwc_step.sv
// Builds the next smaller same-weight word: bits above the pivot are kept,
// the pivot one drops by a place, and the tail ones pack directly under it.
module cwc_step #(
  parameter int unsigned M  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [M-1:0]  word_i,
  input  logic [IW-1:0] pos_i,
  input  logic [IW-1:0] cnt_i,
  output logic [M-1:0]  next_o
);
  always_comb begin
    for (int j = 0; j < int'(M); j++) begin
      if (j > int'(pos_i))
        next_o[j] = word_i[j];
      else if (j == int'(pos_i) - 1)
        next_o[j] = 1'b1;
      else if (j < int'(pos_i) - 1 && j >= int'(pos_i) - 1 - int'(cnt_i))
        next_o[j] = 1'b1;
      else
        next_o[j] = 1'b0;
    end
  end
endmodule

// File: rtl/cwc_counter.sv
module cwc_counter #(
  parameter int unsigned N = 3,
  parameter int unsigned M = 6
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         adv_i,
  output logic [M-1:0] code_o,
  output logic         last_o
);
  import cwc_pkg::*;

  localparam int unsigned IW     = cw_idx_width(M);
  localparam int unsigned PERIOD = cw_choose(N, M);
  localparam int unsigned PW     = $clog2(PERIOD + 1);
  localparam logic [M-1:0] FIRST = ~({M{1'b1}} >> N);
  localparam logic [M-1:0] FINAL = ~({M{1'b1}} << N);

  logic [M-1:0]  code_q;
  logic [M-1:0]  step_w;
  logic [IW-1:0] pos_w;
  logic [IW-1:0] cnt_w;
  logic          found_w;

  cwc_pivot_find #(.M(M), .IW(IW)) u_pivot (
    .word_i(code_q), .pos_o(pos_w), .found_o(found_w)
  );

  cwc_tail_count #(.M(M), .IW(IW)) u_tail (
    .word_i(code_q), .pos_i(pos_w), .cnt_o(cnt_w)
  );

  cwc_step #(.M(M), .IW(IW)) u_step (
    .word_i(code_q), .pos_i(pos_w), .cnt_i(cnt_w), .next_o(step_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)
      code_q <= FIRST;
    else if (adv_i)
      code_q <= last_o ? FIRST : step_w;
  end

  assign code_o = code_q;
  assign last_o = (code_q == FINAL);

  // Advance counter used only by the period check.
  logic [PW-1:0] nadv_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)
      nadv_q <= '0;
    else if (adv_i)
      nadv_q <= last_o ? '0 : nadv_q + 1'b1;
  end

  assert_reset_first_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> code_q == FIRST);

  assert_weight_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> $countones(code_q) == int'(N));

  assert_descend_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i && !last_o |=> code_q < $past(code_q));

  assert_flag_pivot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> last_o == !found_w);

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i && last_o |=> code_q == FIRST);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(code_q));

  assert_period_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && adv_i && last_o |-> nadv_q == PW'(PERIOD - 1));

endmodule

// File: tb/test_cwc_counter.sv
module test_cwc_counter;
  localparam int unsigned N = 3;
  localparam int unsigned M = 6;

  logic clk = 1'b0;
  logic rst, adv;
  logic [M-1:0] code;
  logic last;
  logic sm_adv;
  logic [3:0] sm_code;
  logic sm_last;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cwc_counter #(.N(N), .M(M)) i_cwc_counter (
    .clk_i(clk), .rst_i(rst), .adv_i(adv), .code_o(code), .last_o(last)
  );

  cwc_counter #(.N(2), .M(4)) i_cwc_small (
    .clk_i(clk), .rst_i(rst), .adv_i(sm_adv), .code_o(sm_code), .last_o(sm_last)
  );

  function automatic logic [M-1:0] ref_first();
    logic [M-1:0] v = '0;
    for (int i = 0; i < int'(N); i++) v[M-1-i] = 1'b1;
    return v;
  endfunction

  function automatic logic [M-1:0] ref_next(input logic [M-1:0] v);
    for (int x = int'(v) - 1; x >= 0; x--) begin
      if ($countones(M'(x)) == int'(N)) return M'(x);
    end
    return ref_first();
  endfunction

  function automatic bit ref_last(input logic [M-1:0] v);
    return v == M'((1 << N) - 1);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [M-1:0] exp_code;
  logic [3:0] sm_seq [7];

  initial begin
    void'($urandom(32'd20240607));
    sm_seq[0] = 4'b1100; sm_seq[1] = 4'b1010; sm_seq[2] = 4'b1001;
    sm_seq[3] = 4'b0110; sm_seq[4] = 4'b0101; sm_seq[5] = 4'b0011;
    sm_seq[6] = 4'b1100;
    rst = 1'b1; adv = 1'b0; sm_adv = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_code = ref_first();
    // Reset state (R1, R4)
    check("R1 reset word", code, exp_code);
    check("R4 flag after reset", last, 0);
    check("R1 small reset", sm_code, sm_seq[0]);

    // Directed: 2-of-4 listed order and wrap (R7, R5, R4)
    for (int k = 1; k < 7; k++) begin
      sm_adv = 1'b1;
      @(negedge clk);
      check("R7 small order", sm_code, sm_seq[k]);
      check("R4 small flag", sm_last, k == 5);
    end
    sm_adv = 1'b0;

    // Directed: full period with adv held high (R7, R3, R5)
    adv = 1'b1;
    for (int k = 0; k < 20; k++) begin
      exp_code = ref_next(exp_code);
      @(negedge clk);
      check("R3 step", code, exp_code);
    end
    check("R7 period returns to first", code, ref_first());
    adv = 1'b0;

    // Directed: hold while idle (R6)
    repeat (5) begin
      @(negedge clk);
      check("R6 hold", code, exp_code);
    end

    // Random advance patterns (R2, R3, R4, R5, R6)
    for (int k = 0; k < 3000; k++) begin
      bit a;
      a = ($urandom % 100) < ((k / 500) % 2 == 0 ? 70 : 20);
      adv = a;
      if (a) exp_code = ref_next(exp_code);
      @(negedge clk);
      check(a ? "R3/R5 advance" : "R6 hold", code, exp_code);
      check("R2 weight", $countones(code), N);
      check("R4 last flag", last, ref_last(exp_code));
    end
    adv = 1'b0;

    // Reset mid-sequence (R1)
    adv = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; adv = 1'b0;
    exp_code = ref_first();
    check("R1 mid-run reset", code, exp_code);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule